// File: doc/BRIEF.md
# Prioritised Interrupt Collector with Source-Number Enable

The block gathers a wide set of level interrupt inputs and turns them into two requests for a processor: a normal request and a fast request. Each source carries three pieces of configuration: an enable bit, a routing bit that sends it to the fast request instead of the normal one, and a 4-bit priority. Among the enabled normal-routed sources that are high, an arbiter picks one winner. The winner's number is presented together with a valid flag.

Software drives the block through a simple single-cycle register port. Two write-only registers take a source number. A write to one of them turns on just that source's enable bit, and a write to the other turns it off, so no read-modify-write is needed. The enable and routing vectors can also be written and read whole, one 32-bit word at a time. This lets a suspend sequence install a reduced enable set and later restore the saved one. A threshold register can hold back normal requests whose winning priority is not above a chosen level. All results leave through a register stage.

Top module: `intc_vec`

## Requirements
- R1: After reset all enable bits and routing bits read 0, every priority field reads 0, the threshold register (word address 2) reads 0x1F, and all four result outputs are low or zero.
- R2: A write of value n to word address 0 sets enable bit n and changes no other enable bit. A value of N_SRC or more (any of bits 31:6 set, with 64 sources) changes nothing.
- R3: A write of value n to word address 1 clears enable bit n and changes no other enable bit. A value of N_SRC or more changes nothing.
- R4: The enable vector sits at word addresses 4 (sources 0–31 at bit n) and 5 (sources 32–63 at bit n−32). These words can be written whole and read back unchanged.
- R5: The routing vector sits at word addresses 8 and 9 with the same bit layout as R4. A 1 routes the source to the fast request. The fast request is high when any enabled, high, fast-routed source exists.
- R6: A source whose enable bit is 0 has no effect on any output, whatever its input level.
- R7: Priorities sit at word addresses 16 to 23. Source 8k+j uses bits 4j+3:4j of word 16+k, and 15 is the highest value. The valid flag is high when any enabled, high, normal-routed source exists, and the number output then shows the one with the greatest priority. When the flag is low the number output is 0.
- R8: When two or more candidates share the greatest priority, the one with the higher source number wins.
- R9: Fast-routed sources never take part in the normal arbitration and never appear on the number output.
- R10: While the threshold value is below 16, the normal request is high only if a winner exists and its priority is strictly greater than the threshold. At 16 or above the normal request follows the valid flag. The threshold never affects the valid flag or the number output.
- R11: A change on the source inputs sampled at a clock edge shows on the outputs right after that edge. A register write sampled at an edge shows on the outputs after the following edge. Until then the outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Level interrupt inputs, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 5 | Register read word address |
| rd_data_o | output | 32 | Register read data, combinational from rd_addr_i |
| norm_req_o | output | 1 | Normal interrupt request |
| fast_req_o | output | 1 | Fast interrupt request |
| vec_vld_o | output | 1 | A normal winner exists |
| vec_num_o | output | $clog2(N_SRC) | Number of the winning normal source |

## Verification
Source-input changes are due on the outputs one clock after they are applied. Register writes are due two clocks after. The read port answers in the same cycle. For every stimulus the driver records the edge count at which each result is due and pushes an expected item tagged with that count. A write pushes two items: the old result for the first edge, to show it has not yet taken effect, and the new result for the second edge. A monitor at each falling edge pops and compares only the items whose due count matches. Expected values come from a reference model in the bench that decodes the written words by itself.

// File: rtl/intc_vec_pkg.sv
package intc_vec_pkg;

    // Register word addresses
    localparam int A_ENA_NUM   = 0;
    localparam int A_DIS_NUM   = 1;
    localparam int A_MASK      = 2;
    localparam int A_ENA_BASE  = 4;
    localparam int A_TYP_BASE  = 8;
    localparam int A_PRIO_BASE = 16;

endpackage

// File: rtl/intc_vec_regs.sv
module intc_vec_regs
    import intc_vec_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4,
    parameter int DW     = 32,
    parameter int AW     = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [AW-1:0]             rd_addr,
    output logic [DW-1:0]             rd_data,
    output logic [N_SRC-1:0]          en_o,
    output logic [N_SRC-1:0]          typ_o,
    output logic [N_SRC*PRIO_W-1:0]   prio_o,
    output logic [PRIO_W:0]           mask_o
);

    localparam int IW  = $clog2(N_SRC);
    localparam int MW  = PRIO_W + 1;
    localparam int NW  = N_SRC / DW;
    localparam int PPW = DW / PRIO_W;
    localparam int NPW = N_SRC / PPW;

    typedef struct packed {
        logic [N_SRC-1:0]        en;
        logic [N_SRC-1:0]        typ;
        logic [N_SRC*PRIO_W-1:0] prio;
        logic [MW-1:0]           mask;
    } reg_t;

    reg_t st_d, st_q;
    logic num_ok;

    assign num_ok = (wr_data[DW-1:IW] == '0);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (int'(wr_addr) == A_ENA_NUM && num_ok) begin
                st_d.en[wr_data[IW-1:0]] = 1'b1;
            end
            if (int'(wr_addr) == A_DIS_NUM && num_ok) begin
                st_d.en[wr_data[IW-1:0]] = 1'b0;
            end
            if (int'(wr_addr) == A_MASK) begin
                st_d.mask = wr_data[MW-1:0];
            end
            for (int w = 0; w < NW; w++) begin
                if (int'(wr_addr) == A_ENA_BASE + w) begin
                    st_d.en[w*DW +: DW] = wr_data;
                end
                if (int'(wr_addr) == A_TYP_BASE + w) begin
                    st_d.typ[w*DW +: DW] = wr_data;
                end
            end
            for (int k = 0; k < NPW; k++) begin
                if (int'(wr_addr) == A_PRIO_BASE + k) begin
                    st_d.prio[k*DW +: DW] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= '0;
            st_q.typ  <= '0;
            st_q.prio <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) == A_MASK) begin
            rd_data[MW-1:0] = st_q.mask;
        end
        for (int w = 0; w < NW; w++) begin
            if (int'(rd_addr) == A_ENA_BASE + w) begin
                rd_data = st_q.en[w*DW +: DW];
            end
            if (int'(rd_addr) == A_TYP_BASE + w) begin
                rd_data = st_q.typ[w*DW +: DW];
            end
        end
        for (int k = 0; k < NPW; k++) begin
            if (int'(rd_addr) == A_PRIO_BASE + k) begin
                rd_data = st_q.prio[k*DW +: DW];
            end
        end
    end

    assign en_o   = st_q.en;
    assign typ_o  = st_q.typ;
    assign prio_o = st_q.prio;
    assign mask_o = st_q.mask;

endmodule

// File: rtl/intc_vec_arb.sv
module intc_vec_arb #(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4
) (
    input  logic [N_SRC-1:0]           cand,
    input  logic [N_SRC*PRIO_W-1:0]    prio,
    output logic                       win_vld,
    output logic [$clog2(N_SRC)-1:0]   win_idx,
    output logic [PRIO_W-1:0]          win_prio
);

    localparam int IW  = $clog2(N_SRC);
    localparam int LVL = $clog2(N_SRC);

    typedef struct packed {
        logic              v;
        logic [PRIO_W-1:0] p;
        logic [IW-1:0]     i;
    } node_t;

    node_t leaf [N_SRC];
    node_t nd   [N_SRC];

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_leaf
        assign leaf[gi].v = cand[gi];
        assign leaf[gi].p = {PRIO_W{cand[gi]}} & prio[gi*PRIO_W +: PRIO_W];
        assign leaf[gi].i = IW'(gi);
    end

    // Pairwise tournament, reduced in place; the right (higher-numbered)
    // entry wins on equal priority.
    always_comb begin
        nd = leaf;
        for (int lv = 0; lv < LVL; lv++) begin
            for (int k = 0; k < (N_SRC >> (lv + 1)); k++) begin
                if (nd[2*k+1].v && (!nd[2*k].v || nd[2*k+1].p >= nd[2*k].p)) begin
                    nd[k] = nd[2*k+1];
                end else begin
                    nd[k] = nd[2*k];
                end
            end
        end
    end

    assign win_vld  = nd[0].v;
    assign win_idx  = nd[0].i;
    assign win_prio = nd[0].p;

endmodule

// File: rtl/intc_vec.sv
module intc_vec #(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4,
    parameter int DW     = 32,
    parameter int AW     = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SRC-1:0]           src_i,
    input  logic                       wr_en_i,
    input  logic [AW-1:0]              wr_addr_i,
    input  logic [DW-1:0]              wr_data_i,
    input  logic [AW-1:0]              rd_addr_i,
    output logic [DW-1:0]              rd_data_o,
    output logic                       norm_req_o,
    output logic                       fast_req_o,
    output logic                       vec_vld_o,
    output logic [$clog2(N_SRC)-1:0]   vec_num_o
);

    localparam int IW = $clog2(N_SRC);
    localparam int MW = PRIO_W + 1;

    typedef struct packed {
        logic          norm;
        logic          fast;
        logic          vld;
        logic [IW-1:0] num;
    } out_t;

    logic [N_SRC-1:0]        en_w;
    logic [N_SRC-1:0]        typ_w;
    logic [N_SRC*PRIO_W-1:0] prio_w;
    logic [MW-1:0]           mask_w;
    logic [N_SRC-1:0]        pend;
    logic [N_SRC-1:0]        cand_n;
    logic                    win_vld;
    logic [IW-1:0]           win_idx;
    logic [PRIO_W-1:0]       win_prio;
    out_t                    out_d, out_q;

    intc_vec_regs #(
        .N_SRC (N_SRC),
        .PRIO_W(PRIO_W),
        .DW    (DW),
        .AW    (AW)
    ) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en_i),
        .wr_addr(wr_addr_i),
        .wr_data(wr_data_i),
        .rd_addr(rd_addr_i),
        .rd_data(rd_data_o),
        .en_o   (en_w),
        .typ_o  (typ_w),
        .prio_o (prio_w),
        .mask_o (mask_w)
    );

    assign pend   = src_i & en_w;
    assign cand_n = pend & ~typ_w;

    intc_vec_arb #(
        .N_SRC (N_SRC),
        .PRIO_W(PRIO_W)
    ) i_arb (
        .cand    (cand_n),
        .prio    (prio_w),
        .win_vld (win_vld),
        .win_idx (win_idx),
        .win_prio(win_prio)
    );

    always_comb begin
        out_d.fast = |(pend & typ_w);
        out_d.vld  = win_vld;
        out_d.num  = win_vld ? win_idx : '0;
        // Threshold MSB set means no masking of normal priorities
        out_d.norm = win_vld && (mask_w[MW-1] || (win_prio > mask_w[PRIO_W-1:0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign norm_req_o = out_q.norm;
    assign fast_req_o = out_q.fast;
    assign vec_vld_o  = out_q.vld;
    assign vec_num_o  = out_q.num;

endmodule

// File: rtl/intc_vec_chk.sv
module intc_vec_chk
    import intc_vec_pkg::*;
#(
    parameter int N_SRC = 64,
    parameter int DW    = 32,
    parameter int AW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src,
    input logic [N_SRC-1:0] en,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [DW-1:0]    wr_data,
    input logic             norm,
    input logic             fast,
    input logic             vld
);

    localparam int IW = $clog2(N_SRC);

    logic set_wr, clr_wr;
    assign set_wr = wr_en && (int'(wr_addr) == A_ENA_NUM) && (wr_data[DW-1:IW] == '0);
    assign clr_wr = wr_en && (int'(wr_addr) == A_DIS_NUM) && (wr_data[DW-1:IW] == '0);

    // R2: a numbered enable write sets that source's bit
    a_r2_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> en[$past(wr_data[IW-1:0])]);

    // R3: a numbered disable write clears that source's bit
    a_r3_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !en[$past(wr_data[IW-1:0])]);

    // R2 / R3: a numbered write touches at most one enable bit
    a_r2_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr || clr_wr) |=> ($countones(en ^ $past(en)) <= 1));

    // R6: no active input means no request and no winner on the next cycle
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |=> (!norm && !fast && !vld));

    // R10: a normal request always comes with a winner
    a_r10_req_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
        norm |-> vld);

    // R5: a fast request needs some input high one cycle earlier
    a_r5_fast_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        fast |-> $past(src != '0));

endmodule

bind intc_vec intc_vec_chk #(
    .N_SRC(N_SRC),
    .DW   (DW),
    .AW   (AW)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (src_i),
    .en     (en_w),
    .wr_en  (wr_en_i),
    .wr_addr(wr_addr_i),
    .wr_data(wr_data_i),
    .norm   (norm_req_o),
    .fast   (fast_req_o),
    .vld    (vec_vld_o)
);

// File: tb/test_intc_vec.sv
module test_intc_vec;

    localparam int N  = 64;
    localparam int PW = 4;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          norm, fast, vld;
    logic [5:0]    num;

    intc_vec i_intc_vec (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .norm_req_o(norm), .fast_req_o(fast),
        .vec_vld_o(vld), .vec_num_o(num)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int         due;
        logic       n;
        logic       f;
        logic       v;
        logic [5:0] num;
        string      req;
    } exp_t;

    exp_t sb[$];

    // Reference model of the configuration
    logic [N-1:0] m_en  = '0;
    logic [N-1:0] m_typ = '0;
    logic [3:0]   m_pr [N];
    logic [4:0]   m_mask = 5'h1F;

    function automatic exp_t model(input logic [N-1:0] s);
        exp_t e;
        int   best;
        best  = -1;
        e.f   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (s[i] && m_en[i]) begin
                if (m_typ[i]) e.f = 1'b1;
                else if (best < 0 || m_pr[i] >= m_pr[best]) best = i;
            end
        end
        e.v   = (best >= 0);
        e.num = e.v ? 6'(best) : 6'd0;
        e.n   = e.v && (m_mask[4] || m_pr[best] > m_mask[3:0]);
        e.due = 0;
        e.req = "";
        return e;
    endfunction

    task automatic push(input exp_t e, input int due, input string req);
        e.due = due;
        e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare items due at this falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.due != cyc || norm !== e.n || fast !== e.f || vld !== e.v || num !== e.num) begin
                fails++;
                $display("FAIL %s: n/f/v/num act=%b/%b/%b/%0d exp=%b/%b/%b/%0d (due %0d at %0d)",
                         e.req, norm, fast, vld, num, e.n, e.f, e.v, e.num, e.due, cyc);
            end
        end
    end

    task automatic model_write(input int a, input logic [DW-1:0] d);
        if (a == 0 && d < 32'(N)) m_en[d[5:0]] = 1'b1;
        if (a == 1 && d < 32'(N)) m_en[d[5:0]] = 1'b0;
        if (a == 2) m_mask = d[4:0];
        if (a == 4) m_en[31:0]   = d;
        if (a == 5) m_en[63:32]  = d;
        if (a == 8) m_typ[31:0]  = d;
        if (a == 9) m_typ[63:32] = d;
        if (a >= 16 && a < 24) begin
            for (int j = 0; j < 8; j++) m_pr[(a - 16) * 8 + j] = d[4*j +: 4];
        end
    endtask

    // Driver: a write is due on the outputs two edges later (R11)
    task automatic do_write(input int a, input logic [DW-1:0] d, input string req);
        exp_t old_e, new_e;
        old_e = model(src);
        model_write(a, d);
        new_e = model(src);
        push(old_e, cyc + 1, "R11");
        push(new_e, cyc + 2, req);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    // Driver: an input change is due one edge later
    task automatic set_src(input logic [N-1:0] v, input string req);
        push(model(v), cyc + 1, req);
        src = v;
        @(negedge clk);
    endtask

    task automatic rd_chk(input int a, input logic [DW-1:0] exp, input string req);
        rd_addr = AW'(a);
        #1;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: read addr %0d act=%h exp=%h", req, a, rd_data, exp);
        end
    endtask

    task automatic set_prio(input int idx, input logic [3:0] p, input string req);
        logic [DW-1:0] w;
        int k;
        k = idx / 8;
        for (int j = 0; j < 8; j++) w[4*j +: 4] = m_pr[k*8 + j];
        w[4*(idx % 8) +: 4] = p;
        do_write(16 + k, w, req);
    endtask

    initial begin
        logic [N-1:0] pat;
        logic [DW-1:0] w;
        for (int i = 0; i < N; i++) m_pr[i] = 4'd0;

        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (norm !== 1'b0 || fast !== 1'b0 || vld !== 1'b0 || num !== 6'd0) begin
            fails++;
            $display("FAIL R1: outputs in reset act=%b%b%b/%0d exp=000/0", norm, fast, vld, num);
        end
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(4, 32'h0, "R1");
        rd_chk(5, 32'h0, "R1");
        rd_chk(8, 32'h0, "R1");
        rd_chk(9, 32'h0, "R1");
        rd_chk(2, 32'h1F, "R1");
        rd_chk(16, 32'h0, "R1");
        rd_chk(23, 32'h0, "R1");

        // R7: program priorities p(i) = (7*i) mod 16
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 8; j++) w[4*j +: 4] = 4'((7 * (k*8 + j)) % 16);
            do_write(16 + k, w, "R7");
            rd_chk(16 + k, w, "R7");
        end

        // R6: all inputs high, nothing enabled
        set_src('1, "R6");
        @(negedge clk);

        // R2: numbered enable
        do_write(0, 32'd5, "R2");
        rd_chk(4, 32'h0000_0020, "R2");
        do_write(0, 32'd40, "R2");
        do_write(0, 32'd63, "R7");
        rd_chk(5, 32'h8000_0100, "R2");
        do_write(0, 32'd74, "R2");
        rd_chk(4, 32'h0000_0020, "R2");
        do_write(0, 32'h8000_000A, "R2");
        rd_chk(4, 32'h0000_0020, "R2");
        rd_chk(5, 32'h8000_0100, "R2");

        // R8: tie between 40 and 63 at priority 9
        set_prio(40, 4'd9, "R8");
        // R7: 40 raised to 15 takes over
        set_prio(40, 4'd15, "R7");

        // R5 / R9: route 40 to fast
        do_write(9, 32'h0000_0100, "R5");
        rd_chk(9, 32'h0000_0100, "R5");
        set_src(64'h0000_0100_0000_0000, "R9");
        set_src('1, "R5");

        // R10: threshold
        do_write(2, 32'd9, "R10");
        do_write(2, 32'd8, "R10");
        do_write(2, 32'd15, "R10");
        do_write(2, 32'h10, "R10");
        rd_chk(2, 32'h10, "R10");
        do_write(2, 32'h1F, "R10");

        // R3: numbered disable
        do_write(1, 32'd63, "R3");
        rd_chk(5, 32'h0000_0100, "R3");
        rd_chk(4, 32'h0000_0020, "R3");
        do_write(1, 32'd69, "R3");
        rd_chk(4, 32'h0000_0020, "R3");

        // R4: whole-word enable install and restore
        do_write(4, 32'hA5A5_0F0F, "R4");
        do_write(5, 32'h8000_0001, "R4");
        rd_chk(4, 32'hA5A5_0F0F, "R4");
        rd_chk(5, 32'h8000_0001, "R4");
        do_write(4, 32'h0000_0020, "R4");
        do_write(5, 32'h0000_0100, "R4");
        rd_chk(4, 32'h0000_0020, "R4");
        do_write(4, 32'hFFFF_FFFF, "R4");
        do_write(5, 32'hFFFF_FFFF, "R4");

        // R6 / R7 / R8: varied input patterns
        pat = 64'h9E37_79B9_7F4A_7C15;
        for (int t = 0; t < 12; t++) begin
            pat = pat ^ (pat << 13);
            pat = pat ^ (pat >> 7);
            pat = pat ^ (pat << 17);
            set_src(pat, "R7");
        end
        do_write(5, 32'h0, "R6");
        set_src(64'hFFFF_FFFF_0000_0000, "R6");
        set_src('0, "R6");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R11: %0d expected results never compared act=%0d exp=0", sb.size(), sb.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R11: watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule